// File: doc/BRIEF.md
# UART Line Status Register Unit

This block keeps the receive and transmit status word of a UART. A receiver framer hands it assembled characters, each with parity-error, framing-error and break indications. These go into a 16-entry receive FIFO, where every entry stores its data byte beside three error tags. The host pops characters through a data read port and samples an eight-bit status word through a register read port. The upper 24 bits of that word read as zero.

The error bits are tied to the character at the head of the FIFO, not to the one that arrived last. The overrun, parity, framing and break bits clear when the status word is read. Bit 7 is a summary bit. It stays set while any errored character is still stored, and a status read clears it only after the last such character has left.

On the transmit side, a host write fills the holding register and a load strobe from the shifter empties it. The shifter itself is seen only through a busy input. The status word is a combinational view of registered state, plus the busy input for bit 6.

Top module: `uart_lsr_unit`

## Requirements
- R1: Bit 0 (data ready) is 1 exactly when the receive FIFO is not empty. A data read (`rbr_rd_i`) pops the head entry, and `rbr_data_o` shows the head byte, or zero when the FIFO is empty. A data read of an empty FIFO has no effect.
- R2: The receive FIFO holds 16 characters and returns them in arrival order.
- R3: Bit 1 (overrun) is set in the cycle after a character arrives while the FIFO holds 16 entries and no data read occurs in that cycle. The new character is dropped and the stored ones are kept. A full FIFO that is popped in the same cycle accepts the new character without overrun.
- R4: The tag bits are parity error (tag bit 0), framing error (tag bit 1) and break (tag bit 2). They map to status bits 2, 3 and 4. An entry ORs its tags into these bits in the cycle after it becomes head, either by a push into an empty FIFO or by a pop that exposes it. Errors of entries behind the head do not show.
- R5: A status read (`lsr_rd_i`) clears bits 1 to 4 on the next cycle. If an overrun or a new head entry with tags happens in the same cycle as the read, that new event is what the bits hold afterwards.
- R6: Bit 5 (holding register empty) is 1 after reset. It is 0 in the cycle after `thr_wr_i` and 1 in the cycle after `thr_take_i`. If both strobes come in the same cycle, the write wins.
- R7: Bit 6 (transmitter empty) is 1 only while bit 5 is 1 and `tx_busy_i` is 0.
- R8: Bit 7 (FIFO error) is set in the cycle after a character with any tag set is accepted. A status read clears it only if no tagged character remains once that cycle's pop is done. Otherwise it stays set.
- R9: Bits 31 to 8 of `lsr_o` are zero, and a status read does not pop the FIFO.
- R10: After reset the FIFO is empty, bits 0 to 4 and bit 7 are 0, and bit 5 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Framer delivers a character this cycle |
| rx_data_i | input | 8 | Received character |
| rx_perr_i | input | 1 | Parity error on the character |
| rx_ferr_i | input | 1 | Framing error on the character |
| rx_brk_i | input | 1 | Break condition on the character |
| rbr_rd_i | input | 1 | Host data read; pops the FIFO head |
| rbr_data_o | output | 8 | Head character |
| lsr_rd_i | input | 1 | Host status read strobe |
| lsr_o | output | 32 | Status word |
| thr_wr_i | input | 1 | Host write to the transmit holding register |
| thr_take_i | input | 1 | Shifter loads the holding register |
| tx_busy_i | input | 1 | Transmit shift register holds data |

## Verification
The bench drives two collisions on purpose. The first is a status read in the same cycle as an error event: an overrun, or a tagged entry reaching the head through a push into an empty FIFO or through a pop. The second is a status read in the same cycle as a pop that removes the last tagged character, which decides whether bit 7 may clear. Both are set up in directed sequences and then happen often in a long random phase. A behavioural queue model predicts every status bit and the head byte for each cycle, and the bench compares them against the outputs. A new event must survive the read that comes with it.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_tag_t;

  localparam int unsigned TAG_W = $bits(rx_tag_t);
endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  rx_tag_t           push_tag_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              empty_o,
  output logic              ovf_o,
  output logic              head_new_o,
  output rx_tag_t           head_tag_o,
  output logic              err_push_o,
  output logic              err_left_o,
  output logic              err_any_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem_data [DEPTH];
  rx_tag_t           mem_tag  [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr, rd_ptr_inc;
  logic [CW-1:0]     count, count_nxt;
  logic [CW-1:0]     err_cnt, err_cnt_nxt;
  logic              full, pop_ok, push_ok;

  assign full       = (count == FULL_CNT);
  assign empty_o    = (count == '0);
  assign pop_ok     = pop_i && !empty_o;
  assign push_ok    = push_i && (!full || pop_ok);
  assign ovf_o      = push_i && !push_ok;
  assign rd_ptr_inc = rd_ptr + AW'(1);

  assign head_data_o = empty_o ? '0 : mem_data[rd_ptr];

  // a new entry reaches the head through a pop exposing it or a push into an empty queue
  always_comb begin
    head_new_o = 1'b0;
    head_tag_o = '0;
    if (pop_ok && count > CW'(1)) begin
      head_new_o = 1'b1;
      head_tag_o = mem_tag[rd_ptr_inc];
    end else if (push_ok && (empty_o || pop_ok)) begin
      head_new_o = 1'b1;
      head_tag_o = push_tag_i;
    end
  end

  always_comb begin
    count_nxt = count;
    if (push_ok && !pop_ok) count_nxt = count + CW'(1);
    if (pop_ok && !push_ok) count_nxt = count - CW'(1);
  end

  assign err_push_o = push_ok && (|push_tag_i);

  always_comb begin
    err_cnt_nxt = err_cnt;
    if (err_push_o) err_cnt_nxt = err_cnt_nxt + CW'(1);
    if (pop_ok && (|mem_tag[rd_ptr])) err_cnt_nxt = err_cnt_nxt - CW'(1);
  end

  assign err_left_o = (err_cnt_nxt != '0);
  assign err_any_o  = (err_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr_inc;
      count   <= count_nxt;
      err_cnt <= err_cnt_nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) begin
      mem_data[wr_ptr] <= push_data_i;
      mem_tag[wr_ptr]  <= push_tag_i;
    end
  end

  // R3
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> (count == FULL_CNT) && $stable(wr_ptr));

  // R1
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o && $stable(rd_ptr));

  // R8
  err_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt <= count);
endmodule

// File: rtl/lsr_err_flags.sv
module lsr_err_flags
  import uart_lsr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    stat_rd_i,
  input  logic    ovf_i,
  input  logic    head_new_i,
  input  rx_tag_t head_tag_i,
  input  logic    err_push_i,
  input  logic    err_left_i,
  output logic    oe_o,
  output rx_tag_t head_err_o,
  output logic    fifo_err_o
);
  rx_tag_t tag_in;

  assign tag_in = head_new_i ? head_tag_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o       <= 1'b0;
      head_err_o <= '0;
      fifo_err_o <= 1'b0;
    end else begin
      // a read clears; an event arriving in the same cycle survives it
      oe_o       <= (stat_rd_i ? 1'b0 : oe_o) | ovf_i;
      head_err_o <= (stat_rd_i ? '0 : head_err_o) | tag_in;
      if (err_push_i)                   fifo_err_o <= 1'b1;
      else if (stat_rd_i && !err_left_i) fifo_err_o <= 1'b0;
    end
  end

  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !ovf_i && !head_new_i) |=> (!oe_o && head_err_o == '0));

  // R5
  new_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && ovf_i) |=> oe_o);

  // R8
  fifo_err_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_err_o && err_left_i) |=> fifo_err_o);
endmodule

// File: rtl/lsr_tx_status.sv
module lsr_tx_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thr_wr_i,
  input  logic thr_take_i,
  input  logic tx_busy_i,
  output logic thre_o,
  output logic temt_o
);
  logic thr_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         thr_full <= 1'b0;
    else if (thr_wr_i)   thr_full <= 1'b1;
    else if (thr_take_i) thr_full <= 1'b0;
  end

  assign thre_o = !thr_full;
  assign temt_o = !thr_full && !tx_busy_i;

  // R6
  thr_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !thre_o);

  // R7
  temt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temt_o |-> (thre_o && !tx_busy_i));
endmodule

// File: rtl/uart_lsr_unit.sv
module uart_lsr_unit
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic              rbr_rd_i,
  output logic [DATA_W-1:0] rbr_data_o,
  input  logic              lsr_rd_i,
  output logic [STAT_W-1:0] lsr_o,
  input  logic              thr_wr_i,
  input  logic              thr_take_i,
  input  logic              tx_busy_i
);
  localparam int unsigned LSR_BITS = 8;

  rx_tag_t rx_tag, head_tag, head_err;
  logic    empty, ovf, head_new, err_push, err_left, err_any;
  logic    oe, fifo_err, thre, temt;

  assign rx_tag = '{brk: rx_brk_i, ferr: rx_ferr_i, perr: rx_perr_i};

  lsr_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_valid_i),
    .push_data_i (rx_data_i),
    .push_tag_i  (rx_tag),
    .pop_i       (rbr_rd_i),
    .head_data_o (rbr_data_o),
    .empty_o     (empty),
    .ovf_o       (ovf),
    .head_new_o  (head_new),
    .head_tag_o  (head_tag),
    .err_push_o  (err_push),
    .err_left_o  (err_left),
    .err_any_o   (err_any)
  );

  lsr_err_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_rd_i  (lsr_rd_i),
    .ovf_i      (ovf),
    .head_new_i (head_new),
    .head_tag_i (head_tag),
    .err_push_i (err_push),
    .err_left_i (err_left),
    .oe_o       (oe),
    .head_err_o (head_err),
    .fifo_err_o (fifo_err)
  );

  lsr_tx_status u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .thr_wr_i   (thr_wr_i),
    .thr_take_i (thr_take_i),
    .tx_busy_i  (tx_busy_i),
    .thre_o     (thre),
    .temt_o     (temt)
  );

  assign lsr_o = {{(STAT_W-LSR_BITS){1'b0}},
                  fifo_err, temt, thre,
                  head_err.brk, head_err.ferr, head_err.perr,
                  oe, !empty};

  // R8
  fifo_err_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_any |-> lsr_o[7]);

  // R9
  stat_rd_nopop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !rbr_rd_i && !empty) |=> !empty);
endmodule

// File: tb/uart_lsr_unit_bench.sv
module uart_lsr_unit_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic [7:0]  rx_data = 0;
  logic        rbr_rd = 0, lsr_rd = 0, thr_wr = 0, thr_take = 0, tx_busy = 0;
  logic [7:0]  rbr_data;
  logic [31:0] lsr;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // model state
  logic [10:0] q[$];          // {brk, ferr, perr, data}
  logic m_oe, m_pe, m_fe, m_bi, m_rxfe, m_thr_full;

  always #(CLK_P/2) clk = ~clk;

  uart_lsr_unit u_uart_lsr_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr), .rx_brk_i(rx_brk),
    .rbr_rd_i(rbr_rd), .rbr_data_o(rbr_data),
    .lsr_rd_i(lsr_rd), .lsr_o(lsr),
    .thr_wr_i(thr_wr), .thr_take_i(thr_take), .tx_busy_i(tx_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    q.delete();
    m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_rxfe = 0; m_thr_full = 0;
  endtask

  task automatic model_step();
    bit pop_ok, push_ok, ovf, nh;
    logic [2:0] t;
    int errs;
    pop_ok  = rbr_rd && q.size() > 0;
    push_ok = rx_valid && (q.size() < DEPTH || pop_ok);
    ovf     = rx_valid && !push_ok;
    nh      = 0;
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
    if (pop_ok) nh = q.size() > 0;
    else if (push_ok && q.size() == 1) nh = 1;
    t = nh ? q[0][10:8] : 3'b000;
    m_oe = (lsr_rd ? 1'b0 : m_oe) | ovf;
    m_pe = (lsr_rd ? 1'b0 : m_pe) | t[0];
    m_fe = (lsr_rd ? 1'b0 : m_fe) | t[1];
    m_bi = (lsr_rd ? 1'b0 : m_bi) | t[2];
    errs = 0;
    foreach (q[i]) if (q[i][10:8] != 0) errs++;
    if (push_ok && {rx_brk, rx_ferr, rx_perr} != 0) m_rxfe = 1;
    else if (lsr_rd && errs == 0) m_rxfe = 0;
    if (thr_wr) m_thr_full = 1;
    else if (thr_take) m_thr_full = 0;
  endtask

  task automatic compare();
    logic thre;
    thre = !m_thr_full;
    chk("R1 data ready", lsr[0], q.size() > 0);
    chk("R2 head data", rbr_data, q.size() > 0 ? q[0][7:0] : 8'h00);
    chk("R3 R5 overrun", lsr[1], m_oe);
    chk("R4 R5 parity/framing/break", lsr[4:2], {m_bi, m_fe, m_pe});
    chk("R6 holding empty", lsr[5], thre);
    chk("R7 tx empty", lsr[6], thre && !tx_busy);
    chk("R8 fifo error", lsr[7], m_rxfe);
    chk("R9 upper bits", lsr[31:8], 0);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit v, input logic [7:0] d, input logic [2:0] tg,
                     input bit pop, input bit srd,
                     input bit wr = 0, input bit take = 0, input bit busy = 0);
    rx_valid = v; rx_data = d; {rx_brk, rx_ferr, rx_perr} = tg;
    rbr_rd = pop; lsr_rd = srd; thr_wr = wr; thr_take = take; tx_busy = busy;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset status", lsr, 32'h0000_0060);
    chk("R10 reset data", rbr_data, 0);
    rst_n = 1;
    idle(2);

    // R1 R2 basic order
    cyc(1, 8'h11, 0, 0, 0);
    cyc(1, 8'h22, 0, 0, 0);
    cyc(1, 8'h33, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);        // R9 status read keeps data
    chk("R9 no pop on status read", rbr_data, 8'h11);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0);   // last pop on empty: R1
    chk("R1 empty after pops", lsr[0], 0);

    // R4 error follows head: clean head, parity error second
    cyc(1, 8'hA0, 0, 0, 0);
    cyc(1, 8'hA1, 3'b001, 0, 0);
    chk("R4 hidden error behind head", lsr[2], 0);
    chk("R8 summary set", lsr[7], 1);
    cyc(0, 0, 0, 1, 0);
    chk("R4 parity after pop", lsr[2], 1);
    // R5 read + pop of last errored entry same cycle: R8 clears
    cyc(0, 0, 0, 1, 1);
    chk("R5 cleared", lsr[4:2], 0);
    chk("R8 summary cleared", lsr[7], 0);

    // R5 read same cycle as tagged push into empty FIFO
    cyc(1, 8'hB0, 3'b110, 0, 1);
    chk("R5 new event wins", lsr[4:3], 2'b11);
    cyc(1, 8'hB1, 0, 0, 1);
    chk("R8 summary kept while errored stored", lsr[7], 1);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 1);
    chk("R8 clear when none left", lsr[7], 0);

    // R3 overrun
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(8'h40 + i), 0, 0, 0);
    cyc(1, 8'hEE, 0, 0, 0);
    chk("R3 overrun set", lsr[1], 1);
    cyc(1, 8'hEF, 0, 1, 1);    // full but popped: accepted, no overrun; read clears
    chk("R3 R5 overrun cleared", lsr[1], 0);
    cyc(1, 8'hF0, 0, 0, 1);    // read + overrun: new wins
    chk("R5 overrun wins over read", lsr[1], 1);
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 1, 0);

    // R6 R7 transmit side
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 write clears", lsr[5], 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 0);
    chk("R6 write wins", lsr[5], 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R7 busy holds temt low", lsr[6:5], 2'b01);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 temt set", lsr[6], 1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r1 = $urandom_range(0, 99);
      int r2 = $urandom_range(0, 99);
      logic [2:0] tg = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      cyc(r1 < 55, 8'($urandom), tg, r2 < 45, $urandom_range(0, 4) == 0,
          $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule